// File: doc/BRIEF.md
# Stop-Clock Power State Controller

This controller takes a request to stop the processor core's clock and turns it into an ordered shutdown. It waits for the next instruction boundary, unless a higher-priority interrupt is pending at that boundary. It then asks execution to halt and waits for any cache flush in progress to finish. After that it stops the prefetch unit and, once prefetch reports idle, gates the core clock off. This first low-power state is Stop Grant.

If the external input clock then goes away, the controller records the deeper Stop Clock state. When the clock returns, it goes back to Stop Grant. Dropping the stop request while in Stop Grant returns the core to Run. Dropping it while still waiting for an instruction boundary cancels the request.

All inputs are sampled on the rising edge of `clk`. Clock presence is an input flag. The outputs are decoded from one registered state, so each output moves on the edge after the input that causes it. There is no data stream, so every pin is a plain level signal.

Top module: `stpclk_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `pstate` is 0 (Run), `core_clk_en` is 1, and `halt_exec` and `prefetch_stop` are 0.
- R2: With `stop_req` high in Run, `halt_exec` stays 0 until an edge samples `insn_boundary`=1 with `hp_irq_pending`=0. `halt_exec` rises in the cycle after that edge.
- R3: An instruction boundary sampled while `hp_irq_pending` is 1 is ignored: `halt_exec` stays 0 until a later boundary with no pending interrupt.
- R4: After `halt_exec` rises, `prefetch_stop` stays 0 while `flush_busy` is 1. It rises in the cycle after the first edge that samples `flush_busy`=0, and it is never 1 while `halt_exec` is 0.
- R5: `core_clk_en` stays 1 while `prefetch_stop` is 1 and `prefetch_idle` is 0. It falls, with `pstate` becoming 1 (Stop Grant), in the cycle after an edge that samples `prefetch_idle`=1.
- R6: In Stop Grant, an edge sampling `clk_present`=0 with `stop_req`=1 moves `pstate` to 2 (Stop Clock). In Stop Clock, an edge sampling `clk_present`=1 returns `pstate` to 1.
- R7: In Stop Grant, an edge sampling `stop_req`=0 returns the block to Run in the next cycle, with all three control outputs released. While waiting for a boundary, `stop_req`=0 cancels the request and no halt occurs.
- R8: `pstate` is 0 for Run and for the waiting steps, 1 for Stop Grant and 2 for Stop Clock. The value 3 never appears.
- R9: In Stop Clock, `stop_req` has no effect: `pstate` stays 2 and `core_clk_en` stays 0 until the clock returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Request to stop the core clock (level) |
| insn_boundary | input | 1 | Strobe marking an instruction boundary |
| hp_irq_pending | input | 1 | A higher-priority interrupt awaits service |
| flush_busy | input | 1 | A cache flush is in progress |
| prefetch_idle | input | 1 | Prefetch unit has no activity |
| clk_present | input | 1 | External input clock is running |
| halt_exec | output | 1 | Request to halt instruction execution |
| prefetch_stop | output | 1 | Request to stop the prefetch unit |
| core_clk_en | output | 1 | Core clock enable |
| pstate | output | 2 | Power state: 0 Run, 1 Stop Grant, 2 Stop Clock |

## Verification
The assertions assume that all inputs are stable around each rising edge, and that `clk_present` changes only after Stop Grant has been reached, as a real clock loss would. The stimulus drives every input on the falling edge and removes `clk_present` only while Stop Grant is shown. `flush_busy` and `prefetch_idle` are held at the levels each step of the sequence needs, for several cycles at a time, so that every gate in the sequence is seen both blocked and released.

// File: rtl/stpclk_pkg.sv
package stpclk_pkg;
  localparam int PS_W = 2;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_WBND   = 3'd1,
    ST_WFLUSH = 3'd2,
    ST_WPF    = 3'd3,
    ST_GRANT  = 3'd4,
    ST_SCLK   = 3'd5
  } seq_st_e;

  localparam logic [PS_W-1:0] PS_RUN   = 2'd0;
  localparam logic [PS_W-1:0] PS_GRANT = 2'd1;
  localparam logic [PS_W-1:0] PS_SCLK  = 2'd2;
endpackage

// File: rtl/stpclk_next.sv
module stpclk_next
  import stpclk_pkg::*;
(
  input  seq_st_e cur,
  input  logic    stop_req,
  input  logic    insn_boundary,
  input  logic    hp_irq_pending,
  input  logic    flush_busy,
  input  logic    prefetch_idle,
  input  logic    clk_present,
  output seq_st_e nxt
);
  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_RUN:    if (stop_req) nxt = ST_WBND;
      ST_WBND: begin
        if (!stop_req)                          nxt = ST_RUN;
        else if (insn_boundary && !hp_irq_pending) nxt = ST_WFLUSH;
      end
      ST_WFLUSH: if (!flush_busy)    nxt = ST_WPF;
      ST_WPF:    if (prefetch_idle)  nxt = ST_GRANT;
      ST_GRANT: begin
        if (!stop_req)        nxt = ST_RUN;
        else if (!clk_present) nxt = ST_SCLK;
      end
      ST_SCLK:   if (clk_present)    nxt = ST_GRANT;
      default:   nxt = ST_RUN;
    endcase
  end
endmodule

// File: rtl/stpclk_outdec.sv
module stpclk_outdec
  import stpclk_pkg::*;
(
  input  seq_st_e         cur,
  output logic            halt_exec,
  output logic            prefetch_stop,
  output logic            core_clk_en,
  output logic [PS_W-1:0] pstate
);
  always_comb begin
    halt_exec     = (cur != ST_RUN) && (cur != ST_WBND);
    prefetch_stop = (cur == ST_WPF) || (cur == ST_GRANT) || (cur == ST_SCLK);
    core_clk_en   = (cur != ST_GRANT) && (cur != ST_SCLK);
    case (cur)
      ST_GRANT: pstate = PS_GRANT;
      ST_SCLK:  pstate = PS_SCLK;
      default:  pstate = PS_RUN;
    endcase
  end
endmodule

// File: rtl/stpclk_ctrl.sv
module stpclk_ctrl
  import stpclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop_req,
  input  logic            insn_boundary,
  input  logic            hp_irq_pending,
  input  logic            flush_busy,
  input  logic            prefetch_idle,
  input  logic            clk_present,
  output logic            halt_exec,
  output logic            prefetch_stop,
  output logic            core_clk_en,
  output logic [PS_W-1:0] pstate
);
  seq_st_e st_q;
  seq_st_e st_d;

  stpclk_next u_next (
    .cur            (st_q),
    .stop_req       (stop_req),
    .insn_boundary  (insn_boundary),
    .hp_irq_pending (hp_irq_pending),
    .flush_busy     (flush_busy),
    .prefetch_idle  (prefetch_idle),
    .clk_present    (clk_present),
    .nxt            (st_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  stpclk_outdec u_dec (
    .cur           (st_q),
    .halt_exec     (halt_exec),
    .prefetch_stop (prefetch_stop),
    .core_clk_en   (core_clk_en),
    .pstate        (pstate)
  );
endmodule

// File: rtl/stpclk_ctrl_chk.sv
module stpclk_ctrl_chk
  import stpclk_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            stop_req,
  input logic            insn_boundary,
  input logic            hp_irq_pending,
  input logic            flush_busy,
  input logic            prefetch_idle,
  input logic            clk_present,
  input logic            halt_exec,
  input logic            prefetch_stop,
  input logic            core_clk_en,
  input logic [PS_W-1:0] pstate
);
  p_halt_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_exec) |-> $past(stop_req && insn_boundary && !hp_irq_pending));

  p_pf_needs_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch_stop |-> halt_exec);

  p_pf_after_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prefetch_stop) |-> $past(!flush_busy));

  p_clk_off_after_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> $past(prefetch_stop && prefetch_idle));

  p_deep_needs_no_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_SCLK && $past(pstate) == PS_GRANT) |-> $past(!clk_present));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_GRANT && !stop_req) |=> (pstate == PS_RUN && core_clk_en && !halt_exec));

  p_no_code3_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pstate != 2'd3);

  p_deep_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_SCLK && !clk_present) |=> (pstate == PS_SCLK && !core_clk_en));
endmodule

bind stpclk_ctrl stpclk_ctrl_chk u_chk (.*);

// File: tb/stpclk_ctrl_tb_top.sv
module stpclk_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, insn_boundary = 0, hp_irq_pending = 0;
  logic flush_busy = 0, prefetch_idle = 0, clk_present = 1;
  logic halt_exec, prefetch_stop, core_clk_en;
  logic [1:0] pstate;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  stpclk_ctrl dut_i (.*);

  // behavioural reference: 0 run,1 wait boundary,2 wait flush,3 wait prefetch,4 grant,5 deep
  int m;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m <= 0;
    else begin
      case (m)
        0: if (stop_req) m <= 1;
        1: if (!stop_req) m <= 0; else if (insn_boundary && !hp_irq_pending) m <= 2;
        2: if (!flush_busy) m <= 3;
        3: if (prefetch_idle) m <= 4;
        4: if (!stop_req) m <= 0; else if (!clk_present) m <= 5;
        5: if (clk_present) m <= 4;
        default: m <= 0;
      endcase
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk(cur_req, "halt_exec", int'(halt_exec), (m >= 2) ? 1 : 0);
    chk(cur_req, "prefetch_stop", int'(prefetch_stop), (m >= 3) ? 1 : 0);
    chk(cur_req, "core_clk_en", int'(core_clk_en), (m < 4) ? 1 : 0);
    chk(cur_req, "pstate", int'(pstate), (m == 4) ? 1 : (m == 5) ? 2 : 0);
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(1);
    cur_req = "R1";
    chk("R1", "pstate in reset", int'(pstate), 0);
    chk("R1", "core_clk_en in reset", int'(core_clk_en), 1);
    wait_cyc(1);
    rst_n = 1;
    wait_cyc(1);
    chk("R1", "halt after reset", int'(halt_exec), 0);

    // R2: request without boundary
    cur_req = "R2";
    stop_req = 1;
    wait_cyc(3);
    chk("R2", "halt w/o boundary", int'(halt_exec), 0);
    // R3: boundary masked by interrupt
    cur_req = "R3";
    insn_boundary = 1; hp_irq_pending = 1;
    wait_cyc(2);
    chk("R3", "halt with irq", int'(halt_exec), 0);
    chk("R8", "pstate while waiting", int'(pstate), 0);
    // R2: boundary accepted, flush busy
    cur_req = "R2";
    hp_irq_pending = 0; flush_busy = 1;
    wait_cyc(1);
    insn_boundary = 0;
    chk("R2", "halt after boundary", int'(halt_exec), 1);
    cur_req = "R4";
    wait_cyc(3);
    chk("R4", "pf stop during flush", int'(prefetch_stop), 0);
    flush_busy = 0;
    wait_cyc(1);
    chk("R4", "pf stop after flush", int'(prefetch_stop), 1);
    cur_req = "R5";
    wait_cyc(2);
    chk("R5", "clk en before idle", int'(core_clk_en), 1);
    prefetch_idle = 1;
    wait_cyc(1);
    chk("R5", "clk en after idle", int'(core_clk_en), 0);
    chk("R5", "pstate grant", int'(pstate), 1);

    // R6: clock removed
    cur_req = "R6";
    wait_cyc(2);
    clk_present = 0;
    wait_cyc(1);
    chk("R6", "pstate deep", int'(pstate), 2);
    cur_req = "R9";
    stop_req = 0;
    wait_cyc(3);
    chk("R9", "deep ignores stop_req", int'(pstate), 2);
    chk("R9", "clk en in deep", int'(core_clk_en), 0);
    cur_req = "R6";
    clk_present = 1;
    wait_cyc(1);
    chk("R6", "back to grant", int'(pstate), 1);
    cur_req = "R7";
    wait_cyc(1);
    chk("R7", "run after release", int'(pstate), 0);
    chk("R7", "clk en after release", int'(core_clk_en), 1);
    chk("R7", "halt after release", int'(halt_exec), 0);

    // R7: cancel before boundary
    prefetch_idle = 0;
    stop_req = 1;
    wait_cyc(3);
    stop_req = 0;
    wait_cyc(2);
    chk("R7", "cancel no halt", int'(halt_exec), 0);

    // fast path: all conditions ready
    cur_req = "R5";
    prefetch_idle = 1; insn_boundary = 1; stop_req = 1;
    wait_cyc(3);
    chk("R5", "fast path clk en still on", int'(core_clk_en), 1);
    wait_cyc(1);
    chk("R5", "fast path clk off", int'(core_clk_en), 0);
    cur_req = "R7";
    stop_req = 0; insn_boundary = 0;
    wait_cyc(2);
    chk("R7", "fast path release", int'(pstate), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule